// File: doc/BRIEF.md
# Timed Handshake Sequencer

This block is a synchronous control sequencer that walks through one request/exchange cycle at a time. The cycle has five states: Ready, Initiating, Waiting, Received and Resetting. Four single-cycle event strobes drive it: request, out, in and end. Each strobe advances the sequence only in the one state that expects it. Two moves depend on elapsed time instead of an event. First, a transaction stuck in Waiting is abandoned after a fixed number of cycles. Second, the final return from Resetting to Ready waits until a saturating tick count passes a programmable threshold.

The threshold comes in on an input bus and is captured when a request is accepted, so it stays fixed for the whole transaction. A build-time parameter picks the point the guard count starts from: either the acceptance of in, or the acceptance of end. A timeout always restarts the guard count. A sticky output flag records that the last transaction was abandoned by timeout, and an idle output marks the Ready state.

Top module: `hsk_seq`

## Requirements
- R1: While and after synchronous reset the state output is 0 (Ready), idle_o is 1 and timeout_o is 0.
- R2: The state codes are Ready=0, Initiating=1, Waiting=2, Received=3, Resetting=4. Request moves Ready to Initiating, out moves Initiating to Waiting, in moves Waiting to Received, and end moves Received to Resetting, each on the clock edge that samples the strobe.
- R3: An in strobe is accepted in any Waiting cycle up to and including the last cycle before the timeout. When in and the timeout fall in the same cycle, the machine goes to Received.
- R4: If no in arrives, the machine stays in Waiting for exactly WAIT_TICKS cycles, counted from entry, and then enters Resetting.
- R5: With CLR_ON_END=0 the guard count restarts when in is accepted. Resetting is left after the cycle in which the count exceeds the latched threshold T. With d cycles from the in edge to the end edge, Resetting lasts max(1, T+2-d) cycles.
- R6: With CLR_ON_END=1 the guard count restarts when end is accepted, so Resetting lasts T+2 cycles.
- R7: A Waiting timeout also restarts the guard count, so Resetting after a timeout lasts T+2 cycles in either mode.
- R8: The guard count saturates at 2^CNT_W-1 and does not wrap, so a long stay in Received does not lengthen Resetting.
- R9: A strobe that the current state does not expect is ignored, and the state output holds.
- R10: timeout_o goes to 1 on the timeout edge. It stays 1 through Resetting and Ready, and drops to 0 on the edge that accepts the next request.
- R11: thr_i is captured on the edge that accepts request. Later changes to it do not affect the current transaction.
- R12: idle_o is 1 exactly when the state output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ev_req_i | input | 1 | Request strobe |
| ev_out_i | input | 1 | Out strobe |
| ev_in_i | input | 1 | In strobe |
| ev_end_i | input | 1 | End strobe |
| thr_i | input | CNT_W | Guard threshold T, captured at request |
| state_o | output | 3 | Encoded state (codes as in R2) |
| idle_o | output | 1 | High in Ready |
| timeout_o | output | 1 | Sticky flag: last Waiting ended by timeout |

## Verification
The bench builds two copies side by side with CNT_W=4 and WAIT_TICKS=5, one with CLR_ON_END=0 and one with CLR_ON_END=1, and drives both with the same strobes. This lets a single stimulus check the two guard reference points against each other. The 4-bit count makes saturation reachable after 16 cycles, where a wrapping counter would give a visibly different Resetting length. The short timeout lets the bench sweep every Waiting cycle for the arrival of in, including the tie with the timeout. The bench also sweeps every pair of threshold 0..6 and Received length 1..6, which covers both the immediate release and the waited release of the guard.

// File: rtl/hsk_pkg.sv
`timescale 1ns/1ps
package hsk_pkg;

    typedef enum logic [2:0] {
        ST_READY = 3'd0,
        ST_INIT  = 3'd1,
        ST_WAIT  = 3'd2,
        ST_RECV  = 3'd3,
        ST_RSET  = 3'd4
    } hsk_state_e;

    typedef struct packed {
        logic req;
        logic out;
        logic inp;
        logic fin;
    } hsk_ev_t;

    // true when the strobe this state listens to is present
    function automatic logic ev_wanted(hsk_state_e s, hsk_ev_t e);
        case (s)
            ST_READY: return e.req;
            ST_INIT:  return e.out;
            ST_WAIT:  return e.inp;
            ST_RECV:  return e.fin;
            default:  return 1'b0;
        endcase
    endfunction

    // successor along the event chain
    function automatic hsk_state_e ev_target(hsk_state_e s);
        case (s)
            ST_READY: return ST_INIT;
            ST_INIT:  return ST_WAIT;
            ST_WAIT:  return ST_RECV;
            ST_RECV:  return ST_RSET;
            default:  return ST_READY;
        endcase
    endfunction

endpackage

// File: rtl/hsk_tick.sv
`timescale 1ns/1ps
module hsk_tick #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (cnt_q != TOP)
            cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt_q == TOP) |=> (cnt_q == TOP)); // R8
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/hsk_ctrl.sv
`timescale 1ns/1ps
module hsk_ctrl
    import hsk_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WW         = 5,
    parameter int WAIT_TICKS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  hsk_ev_t          ev,
    input  logic [CNT_W-1:0] thr_i,
    input  logic [CNT_W-1:0] gcnt,
    input  logic [WW-1:0]    wcnt,
    output hsk_state_e       state_o,
    output logic             took_out,
    output logic             took_in,
    output logic             took_end,
    output logic             tmo_fire,
    output logic             flag_o
);
    localparam logic [WW-1:0] WLAST = WW'(WAIT_TICKS - 1);

    hsk_state_e       state_q, state_d;
    logic [CNT_W-1:0] thr_q;
    logic             flag_q;
    logic             step_ev;
    logic             guard_ok;

    assign step_ev  = ev_wanted(state_q, ev);
    assign tmo_fire = (state_q == ST_WAIT) && !ev.inp && (wcnt >= WLAST);
    assign guard_ok = gcnt > thr_q;

    assign took_out = step_ev && (state_q == ST_INIT);
    assign took_in  = step_ev && (state_q == ST_WAIT);
    assign took_end = step_ev && (state_q == ST_RECV);

    always_comb begin
        state_d = state_q;
        if (step_ev)
            state_d = ev_target(state_q);
        else if (tmo_fire)
            state_d = ST_RSET;
        else if ((state_q == ST_RSET) && guard_ok)
            state_d = ST_READY;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
            thr_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if ((state_q == ST_READY) && step_ev) begin
                thr_q  <= thr_i;
                flag_q <= 1'b0;
            end else if (tmo_fire) begin
                flag_q <= 1'b1;
            end
        end
    end

    assign state_o = state_q;
    assign flag_o  = flag_q;

    AST_RESET_READY: assert property (@(posedge clk)
        rst |=> (state_q == ST_READY && !flag_q)); // R1
    AST_REQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_READY && ev.req) |=> (state_q == ST_INIT)); // R2
    AST_IN_WINS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && ev.inp) |=> (state_q == ST_RECV)); // R3
    AST_WAIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !ev.inp && wcnt >= WLAST) |=> (state_q == ST_RSET)); // R4
    AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RSET && gcnt <= thr_q) |=> (state_q == ST_RSET)); // R5
    AST_HOLD_UNEXPECTED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INIT && !ev.out) |=> $stable(state_q)); // R9
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !ev.inp && wcnt >= WLAST) |=> flag_q); // R10
    AST_THR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_READY) |=> $stable(thr_q)); // R11
endmodule

// File: rtl/hsk_seq.sv
`timescale 1ns/1ps
module hsk_seq
    import hsk_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int WAIT_TICKS = 16,
    parameter bit CLR_ON_END = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_req_i,
    input  logic             ev_out_i,
    input  logic             ev_in_i,
    input  logic             ev_end_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic [2:0]       state_o,
    output logic             idle_o,
    output logic             timeout_o
);
    localparam int WW = $clog2(WAIT_TICKS + 1);

    hsk_ev_t          ev;
    hsk_state_e       st;
    logic [CNT_W-1:0] gcnt;
    logic [WW-1:0]    wcnt;
    logic             took_out, took_in, took_end, tmo_fire;
    logic             gclr;

    assign ev.req = ev_req_i;
    assign ev.out = ev_out_i;
    assign ev.inp = ev_in_i;
    assign ev.fin = ev_end_i;

    // guard reference point: in or end, plus any timeout
    assign gclr = (CLR_ON_END ? took_end : took_in) | tmo_fire;

    hsk_tick #(.W(CNT_W)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .clr   (gclr),
        .cnt_o (gcnt)
    );

    hsk_tick #(.W(WW)) u_wait (
        .clk   (clk),
        .rst   (rst),
        .clr   (took_out),
        .cnt_o (wcnt)
    );

    hsk_ctrl #(
        .CNT_W      (CNT_W),
        .WW         (WW),
        .WAIT_TICKS (WAIT_TICKS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .thr_i    (thr_i),
        .gcnt     (gcnt),
        .wcnt     (wcnt),
        .state_o  (st),
        .took_out (took_out),
        .took_in  (took_in),
        .took_end (took_end),
        .tmo_fire (tmo_fire),
        .flag_o   (timeout_o)
    );

    assign state_o = st;
    assign idle_o  = (st == ST_READY);
endmodule

// File: tb/hsk_seq_test.sv
`timescale 1ns/1ps
module hsk_seq_test;
    localparam int W  = 4;
    localparam int WT = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rq = 1'b0, ou = 1'b0, ii = 1'b0, en = 1'b0;
    logic [W-1:0] thr = '0;
    logic [2:0]   st_a, st_b;
    logic         idle_a, idle_b, to_a, to_b;
    int           nchk = 0;
    int           nerr = 0;

    hsk_seq #(.CNT_W(W), .WAIT_TICKS(WT), .CLR_ON_END(1'b0)) uut (
        .clk(clk), .rst(rst), .ev_req_i(rq), .ev_out_i(ou), .ev_in_i(ii),
        .ev_end_i(en), .thr_i(thr), .state_o(st_a), .idle_o(idle_a), .timeout_o(to_a));

    hsk_seq #(.CNT_W(W), .WAIT_TICKS(WT), .CLR_ON_END(1'b1)) uut_end (
        .clk(clk), .rst(rst), .ev_req_i(rq), .ev_out_i(ou), .ev_in_i(ii),
        .ev_end_i(en), .thr_i(thr), .state_o(st_b), .idle_o(idle_b), .timeout_o(to_b));

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string r, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    // 0 request, 1 out, 2 in, 3 end
    task automatic pulse(input int which);
        rq = (which == 0); ou = (which == 1); ii = (which == 2); en = (which == 3);
        step();
        rq = 1'b0; ou = 1'b0; ii = 1'b0; en = 1'b0;
    endtask

    task automatic count_rset(output int na, output int nb);
        na = 0; nb = 0;
        for (int k = 0; k < 100 && (st_a == 3'd4 || st_b == 3'd4); k++) begin
            if (st_a == 3'd4) na++;
            if (st_b == 3'd4) nb++;
            step();
        end
    endtask

    function automatic int maxi(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    initial begin
        #(5.0 * 150000);
        nerr++; nchk++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int na, nb, n;
        repeat (3) step();
        chk("R1 state", st_a, 0);   chk("R1 state end-mode", st_b, 0);
        chk("R1 idle", idle_a, 1);  chk("R1 flag", to_a, 0);
        rst = 1'b0;
        step();
        chk("R1 after release", st_a, 0);

        // R9: strobes that are not expected are ignored
        pulse(1); pulse(2); pulse(3);
        chk("R9 ready holds", st_a, 0); chk("R9 ready holds end-mode", st_b, 0);
        chk("R12 idle in ready", idle_a, 1);
        pulse(0);
        chk("R2 request", st_a, 1); chk("R12 idle low", idle_a, 0);
        pulse(2); pulse(3); pulse(0);
        chk("R9 initiating holds", st_a, 1);
        pulse(1);
        chk("R2 out", st_a, 2);
        pulse(3); pulse(0);
        chk("R9 waiting holds", st_a, 2);
        pulse(2);
        chk("R2 in", st_a, 3);
        pulse(0); pulse(1);
        chk("R9 received holds", st_a, 3);
        pulse(3);
        chk("R2 end", st_a, 4); chk("R2 end end-mode", st_b, 4);
        count_rset(na, nb);
        chk("R5 first pass", na, 1);   // T=0, d=3
        chk("R6 first pass", nb, 2);

        // R5/R6/R11: sweep threshold and Received length
        for (int t = 0; t <= 6; t++) begin
            for (int d = 1; d <= 6; d++) begin
                thr = W'(t);
                pulse(0);
                thr = W'(t + 5);          // R11: must not matter now
                pulse(1); pulse(2);
                repeat (d - 1) step();
                pulse(3);
                count_rset(na, nb);
                chk($sformatf("R5 T=%0d d=%0d", t, d), na, maxi(1, t + 2 - d));
                chk($sformatf("R6 R11 T=%0d d=%0d", t, d), nb, t + 2);
                chk("R12 idle back", idle_a, 1);
            end
        end

        // R3: in accepted in every Waiting cycle, including the tie
        for (int j = 0; j < WT; j++) begin
            thr = W'(2);
            pulse(0); pulse(1);
            repeat (j) step();
            chk($sformatf("R4 still waiting j=%0d", j), st_a, 2);
            pulse(2);
            chk($sformatf("R3 in at j=%0d", j), st_a, 3);
            chk($sformatf("R3 end-mode j=%0d", j), st_b, 3);
            chk("R10 no flag", to_a, 0);
            pulse(3);
            count_rset(na, nb);
        end

        // R4/R7/R10: timeout path
        thr = W'(3);
        pulse(0); pulse(1);
        n = 0;
        for (int k = 0; k < 50 && st_a == 3'd2; k++) begin
            n++;
            step();
        end
        chk("R4 waiting length", n, WT);
        chk("R4 resetting", st_a, 4); chk("R4 resetting end-mode", st_b, 4);
        chk("R10 flag set", to_a, 1); chk("R10 flag set end-mode", to_b, 1);
        count_rset(na, nb);
        chk("R7 after timeout", na, 5); chk("R7 after timeout end-mode", nb, 5);
        chk("R10 flag held in ready", to_a, 1);
        pulse(0);
        chk("R10 flag cleared", to_a, 0); chk("R10 flag cleared end-mode", to_b, 0);
        pulse(1); pulse(2); pulse(3);
        count_rset(na, nb);

        // R8: saturation over a long Received stay
        thr = W'(10);
        pulse(0); pulse(1); pulse(2);
        repeat (39) step();
        pulse(3);
        count_rset(na, nb);
        chk("R8 saturated guard", na, 1);
        chk("R8 end-mode", nb, 12);
        chk("R12 final idle", idle_b, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule